// File: doc/BRIEF.md
# Per-Core Interrupt Priority Threshold Selector

This block is the delivery stage of a small interrupt controller serving two processor cores. It holds, for every interrupt source, a 4-bit priority, a mask bit, a destination bit per core and a pending flag. Each core also has a 4-bit task-priority threshold and a stack of in-service priorities. For each core, the block picks the best source it may deliver. It raises that core's interrupt line and presents the winning source number.

Software configures the block through a single-cycle write port. The port carries source configuration, thresholds, per-core hold bits and interprocessor-interrupt dispatch. Pending flags are set by one-cycle pulses on `src_set`. A core takes an interrupt with an `ack` strobe, which pushes that interrupt's priority onto the core's in-service stack. It finishes the interrupt with an `eoi` strobe, which pops the stack.

Each core has a three-state delivery machine:
- HELD: the core's hold bit is set.
- IDLE: nothing is offered.
- OFFER: the interrupt line is high.

Its transitions are:
- any state to HELD when the hold bit is set.
- HELD to IDLE on release.
- IDLE to OFFER when a candidate exists.
- OFFER to IDLE on `ack` or when no candidate remains.
- OFFER to OFFER with the source number refreshed.

Top module: `irq_thresh_sel`

## Requirements
- R1: Each core has a 4-bit threshold that resets to 15, is written through space 1, and is visible on `thresh_o` (core c in bits [4c+3:4c]).
- R2: A source is delivered to core c only if it is pending, unmasked (mask bit 0), has destination bit c set, and its priority is strictly above both the core's threshold and the top of that core's in-service stack.
- R3: Among the deliverable sources, the one with the highest priority wins. Ties go to the lowest source number.
- R4: With a threshold of 0, every nonzero priority can be delivered, and a priority-0 source is never delivered.
- R5: A threshold of 15 keeps that core's interrupt line low.
- R6: While a core's hold bit is set, its threshold is forced to 15 and threshold writes to it are ignored. After release, the threshold stays 15 until it is written.
- R7: A write to space 3 raises `ipi_o[c]` for exactly one cycle for each set data bit c. Both bits may be set together, and the threshold does not gate these pulses.
- R8: An `ack` while the line is high does three things: it pushes the presented source's priority onto the core's 16-entry in-service stack, clears that source's pending flag, and drops the line for at least the next cycle.
- R9: An `eoi` pops the in-service stack. An empty stack acts as in-service priority 0, and an `eoi` on an empty stack has no effect.
- R10: `irq_o` and `irq_id_o` are registered. A state change captured at clock edge k shows on them after edge k+1.
- R11: Writes are decoded as follows:
  - `wr_addr[5:4]` selects the space: 0 is source configuration, 1 is threshold, 2 is core hold, 3 is interprocessor dispatch.
  - In space 0, `wr_addr[3:0]` is the source number. The data fields are priority `wr_data[3:0]`, mask `wr_data[4]` and destination `wr_data[6:5]`.
  - In space 1, `wr_addr[0]` is the core and the data is `wr_data[3:0]`.
  - Spaces 2 and 3 use `wr_data[1:0]`, one bit per core.
  - Sources reset masked, with priority 0 and no destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write space and index |
| wr_data | input | 7 | Write data |
| src_set | input | 16 | One-cycle pulses that set pending flags |
| ack | input | 2 | Per-core acknowledge strobe |
| eoi | input | 2 | Per-core end-of-interrupt strobe |
| irq_o | output | 2 | Per-core interrupt line |
| irq_id_o | output | 8 | Per-core presented source number, 4 bits each |
| ipi_o | output | 2 | Per-core interprocessor interrupt pulse |
| thresh_o | output | 8 | Per-core threshold, 4 bits each |

## Verification
The bench builds the block with its default parameters: 16 sources, 2 cores, 4-bit priorities and a 16-deep in-service stack. At this size every priority level from 0 to 15 can be reached, a source can be routed to both cores, and nesting can climb through all fifteen nonzero levels. Random traffic on shared sources therefore exercises the cases where one core's acknowledge removes the offer from the other core. It also exercises stacked acknowledges that raise a core's effective floor until only the highest priorities pass.

// File: rtl/irq_thresh_pkg.sv
package irq_thresh_pkg;

    typedef enum logic [1:0] {
        CS_HELD  = 2'd0,
        CS_IDLE  = 2'd1,
        CS_OFFER = 2'd2
    } core_state_e;

    typedef enum logic [1:0] {
        WS_SRC_CFG  = 2'd0,
        WS_THRESH   = 2'd1,
        WS_CORE_RST = 2'd2,
        WS_IPI      = 2'd3
    } wr_space_e;

endpackage

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] elig,
    input  logic [PRIO_W-1:0]  prio [NUM_SRC],
    input  logic [PRIO_W-1:0]  floor_prio,
    output logic               found,
    output logic [SRC_W-1:0]   sel
);

    logic [PRIO_W-1:0] best;

    // Strict comparison against the running best keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = floor_prio;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (prio[i] > best)) begin
                found = 1'b1;
                sel   = SRC_W'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack #(
    parameter int DEPTH  = 16,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] din,
    output logic [PRIO_W-1:0] top
);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic              empty, full, grow, shrink, swap;
    logic [IDX_W-1:0]  top_idx, new_idx;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign top_idx = IDX_W'(cnt - 1'b1);
    assign new_idx = IDX_W'(cnt);
    assign grow    = push && !full && (!pop || empty);
    assign shrink  = pop && !push && !empty;
    assign swap    = push && pop && !empty;
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (grow) begin
            cnt <= cnt + 1'b1;
        end else if (shrink) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (grow) begin
            mem[new_idx] <= din;
        end else if (swap) begin
            mem[top_idx] <= din;
        end
    end

    // R8: nesting is strictly increasing, so a push never meets a full stack
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);

endmodule

// File: rtl/irq_core_fsm.sv
module irq_core_fsm
    import irq_thresh_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             held,
    input  logic             found,
    input  logic [SRC_W-1:0] sel,
    input  logic             ack,
    output logic             irq,
    output logic [SRC_W-1:0] id,
    output logic             ack_take
);

    core_state_e state_q, state_d;
    logic [SRC_W-1:0] id_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HELD:  if (!held)          state_d = CS_IDLE;
            CS_IDLE:  if (found)          state_d = CS_OFFER;
            CS_OFFER: if (ack || !found)  state_d = CS_IDLE;
            default:                      state_d = CS_HELD;
        endcase
        if (held) state_d = CS_HELD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  id_q <= '0;
        else if (state_d == CS_OFFER) id_q <= sel;
    end

    assign irq      = (state_q == CS_OFFER);
    assign id       = id_q;
    assign ack_take = ack && (state_q == CS_OFFER);

endmodule

// File: rtl/irq_thresh_sel.sv
module irq_thresh_sel
    import irq_thresh_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int NUM_CORE  = 2,
    parameter int PRIO_W    = 4,
    parameter int ISR_DEPTH = 16,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CORE_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int ADDR_W   = SRC_W + 2,
    localparam int DATA_W   = PRIO_W + 1 + NUM_CORE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NUM_SRC-1:0]         src_set,
    input  logic [NUM_CORE-1:0]        ack,
    input  logic [NUM_CORE-1:0]        eoi,
    output logic [NUM_CORE-1:0]        irq_o,
    output logic [NUM_CORE*SRC_W-1:0]  irq_id_o,
    output logic [NUM_CORE-1:0]        ipi_o,
    output logic [NUM_CORE*PRIO_W-1:0] thresh_o
);

    localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

    logic [PRIO_W-1:0]   prio_q   [NUM_SRC];
    logic [NUM_CORE-1:0] dest_q   [NUM_SRC];
    logic [NUM_SRC-1:0]  mask_q;
    logic [NUM_SRC-1:0]  pend_q;
    logic [PRIO_W-1:0]   thresh_q [NUM_CORE];
    logic [NUM_CORE-1:0] core_rst_q;
    logic [NUM_CORE-1:0] ipi_q;

    logic [SRC_W-1:0]    core_id  [NUM_CORE];
    logic [NUM_CORE-1:0] ack_take;

    wr_space_e         wr_space;
    logic [SRC_W-1:0]  wr_idx;
    logic [CORE_W-1:0] wr_core;

    assign wr_space = wr_space_e'(wr_addr[ADDR_W-1 -: 2]);
    assign wr_idx   = wr_addr[SRC_W-1:0];
    assign wr_core  = wr_addr[CORE_W-1:0];

    // Source configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                prio_q[i] <= '0;
                dest_q[i] <= '0;
            end
            mask_q <= '1;
        end else if (wr_en && wr_space == WS_SRC_CFG) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_idx == SRC_W'(i)) begin
                    prio_q[i] <= wr_data[PRIO_W-1:0];
                    mask_q[i] <= wr_data[PRIO_W];
                    dest_q[i] <= wr_data[PRIO_W+1 +: NUM_CORE];
                end
            end
        end
    end

    // Pending flags: an acknowledge clears, a new pulse sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                logic clr;
                clr = 1'b0;
                for (int c = 0; c < NUM_CORE; c++) begin
                    if (ack_take[c] && core_id[c] == SRC_W'(i)) clr = 1'b1;
                end
                pend_q[i] <= (pend_q[i] && !clr) || src_set[i];
            end
        end
    end

    // Thresholds, hold bits and dispatch pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CORE; c++) thresh_q[c] <= PRIO_MAX;
            core_rst_q <= '0;
            ipi_q      <= '0;
        end else begin
            for (int c = 0; c < NUM_CORE; c++) begin
                if (core_rst_q[c])
                    thresh_q[c] <= PRIO_MAX;
                else if (wr_en && wr_space == WS_THRESH && wr_core == CORE_W'(c))
                    thresh_q[c] <= wr_data[PRIO_W-1:0];
            end
            if (wr_en && wr_space == WS_CORE_RST)
                core_rst_q <= wr_data[NUM_CORE-1:0];
            ipi_q <= (wr_en && wr_space == WS_IPI) ? wr_data[NUM_CORE-1:0] : '0;
        end
    end

    assign ipi_o = ipi_q;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        logic [NUM_SRC-1:0] elig;
        logic [PRIO_W-1:0]  isr_top;
        logic [PRIO_W-1:0]  floor_v;
        logic               found;
        logic [SRC_W-1:0]   sel;
        logic               irq;

        always_comb begin
            for (int i = 0; i < NUM_SRC; i++)
                elig[i] = pend_q[i] && !mask_q[i] && dest_q[i][c];
        end

        assign floor_v = (thresh_q[c] > isr_top) ? thresh_q[c] : isr_top;

        irq_src_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
            .elig       (elig),
            .prio       (prio_q),
            .floor_prio (floor_v),
            .found      (found),
            .sel        (sel)
        );

        irq_isr_stack #(.DEPTH(ISR_DEPTH), .PRIO_W(PRIO_W)) u_stack (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (ack_take[c]),
            .pop   (eoi[c]),
            .din   (prio_q[core_id[c]]),
            .top   (isr_top)
        );

        irq_core_fsm #(.SRC_W(SRC_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .held     (core_rst_q[c]),
            .found    (found),
            .sel      (sel),
            .ack      (ack[c]),
            .irq      (irq),
            .id       (core_id[c]),
            .ack_take (ack_take[c])
        );

        assign irq_o[c]                      = irq;
        assign irq_id_o[c*SRC_W +: SRC_W]    = core_id[c];
        assign thresh_o[c*PRIO_W +: PRIO_W]  = thresh_q[c];

        // R5: a fully blocking threshold keeps the line low on the next cycle
        assert_block_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (thresh_q[c] == PRIO_MAX) |=> !irq_o[c]);

        // R6: a held core has its threshold pinned to the blocking value
        assert_thresh_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst_q[c] |=> (thresh_q[c] == PRIO_MAX));

        // R8: an accepted acknowledge drops the line
        assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[c] && irq_o[c]) |=> !irq_o[c]);

        // R7: a dispatch pulse appears only after a dispatch write
        assert_ipi_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_o[c] |-> ($past(wr_en) && $past(wr_addr[ADDR_W-1 -: 2]) == 2'd3));
    end

endmodule

// File: tb/irq_thresh_sel_bench.sv
module irq_thresh_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [6:0]  wr_data = '0;
    logic [15:0] src_set = '0;
    logic [1:0]  ack = '0;
    logic [1:0]  eoi = '0;
    logic [1:0]  irq_o;
    logic [7:0]  irq_id_o;
    logic [1:0]  ipi_o;
    logic [7:0]  thresh_o;

    always #4 clk = ~clk;

    irq_thresh_sel u_irq_thresh_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_set(src_set), .ack(ack), .eoi(eoi), .irq_o(irq_o), .irq_id_o(irq_id_o),
        .ipi_o(ipi_o), .thresh_o(thresh_o)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model
    int m_prio [16];
    bit m_mask [16];
    bit [1:0] m_dest [16];
    bit m_pend [16];
    int m_th [2];
    bit m_rst [2];
    int m_stk [2][16];
    int m_sp [2];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_id(input int c);
        int fl, best, bp;
        fl = m_th[c];
        if (m_sp[c] > 0 && m_stk[c][m_sp[c]-1] > fl) fl = m_stk[c][m_sp[c]-1];
        best = -1;
        bp = fl;
        for (int i = 0; i < 16; i++)
            if (m_pend[i] && !m_mask[i] && m_dest[i][c] && m_prio[i] > bp) begin
                best = i;
                bp = m_prio[i];
            end
        return best;
    endfunction

    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            int e;
            e = exp_id(c);
            check("R2/R3 irq line", int'(irq_o[c]), (e >= 0) ? 1 : 0);
            if (e >= 0) check("R3 source id", int'(irq_id_o[c*4 +: 4]), e);
            check("R1 threshold", int'(thresh_o[c*4 +: 4]), m_th[c]);
        end
    endtask

    task automatic wr(input int space, input int idx, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 6'((space << 4) | idx);
        wr_data = 7'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (space == 0) begin
            m_prio[idx] = data & 15;
            m_mask[idx] = data[4];
            m_dest[idx] = 2'(data >> 5);
        end else if (space == 1) begin
            if (!m_rst[idx & 1]) m_th[idx & 1] = data & 15;
        end else if (space == 2) begin
            for (int c = 0; c < 2; c++) begin
                m_rst[c] = data[c];
                if (data[c]) m_th[c] = 15;
            end
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_src(input logic [15:0] v);
        @(negedge clk);
        src_set = v;
        @(negedge clk);
        src_set = '0;
        for (int i = 0; i < 16; i++) if (v[i]) m_pend[i] = 1'b1;
    endtask

    task automatic do_ack(input int c);
        int e;
        @(negedge clk);
        if (irq_o[c]) begin
            e = exp_id(c);
            ack[c] = 1'b1;
            @(negedge clk);
            ack[c] = 1'b0;
            check("R8 line drops after ack", int'(irq_o[c]), 0);
            if (e >= 0) begin
                m_stk[c][m_sp[c]] = m_prio[e];
                m_sp[c]++;
                m_pend[e] = 1'b0;
            end
        end
    endtask

    task automatic do_eoi(input int c);
        @(negedge clk);
        eoi[c] = 1'b1;
        @(negedge clk);
        eoi[c] = 1'b0;
        if (m_sp[c] > 0) m_sp[c]--;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            m_prio[i] = 0; m_mask[i] = 1; m_dest[i] = 0; m_pend[i] = 0;
        end
        for (int c = 0; c < 2; c++) begin
            m_th[c] = 15; m_rst[c] = 0; m_sp[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 reset threshold core0", int'(thresh_o[3:0]), 15);
        check("R1 reset threshold core1", int'(thresh_o[7:4]), 15);
        check("R10 reset irq", int'(irq_o), 0);
        check("R7 reset ipi", int'(ipi_o), 0);

        // R5: threshold 15 blocks an eligible source
        wr(0, 0, 5 | (3 << 5));
        pulse_src(16'h0001);
        settle();
        check("R5 blocked by threshold 15", int'(irq_o), 0);

        // R4: threshold 0, a priority-0 source alone is never delivered
        wr(0, 0, 5 | (1 << 4) | (3 << 5));   // mask source 0 for now
        wr(1, 0, 0);
        wr(0, 3, 0 | (1 << 5));
        pulse_src(16'h0008);
        settle();
        check("R4 priority 0 not delivered", int'(irq_o[0]), 0);
        check_all();

        // R10: latency from a pending change, with R4 nonzero delivery at threshold 0
        wr(0, 0, 5 | (3 << 5));
        settle();
        check("R4 nonzero delivered at threshold 0", int'(irq_o[0]), 1);
        check("R4 source id", int'(irq_id_o[3:0]), 0);
        wr(0, 9, 12 | (1 << 5));
        @(negedge clk);
        src_set = 16'h0200;
        @(negedge clk);                      // pending captured on the edge just passed
        src_set = '0;
        m_pend[9] = 1'b1;
        check("R10 id unchanged one edge after", int'(irq_id_o[3:0]), 0);
        @(negedge clk);
        check("R10 id updated after second edge", int'(irq_id_o[3:0]), 9);
        settle();
        check_all();

        // R3 tie break: two sources at priority 13, lower number wins
        wr(0, 7, 13 | (1 << 5));
        wr(0, 2, 13 | (1 << 5));
        pulse_src(16'h0084);
        settle();
        check("R3 tie to lowest index", int'(irq_id_o[3:0]), 2);

        // R8: ack raises the floor to 13, so source 7 at 13 is blocked
        do_ack(0);
        settle();
        check("R8 equal priority blocked by in-service", int'(irq_o[0]), 0);
        check_all();

        // R9: eoi lets source 7 through
        do_eoi(0);
        settle();
        check("R9 eoi releases source 7", int'(irq_id_o[3:0]), 7);
        check_all();
        do_eoi(0);                           // empty pop: no effect
        do_eoi(0);
        settle();
        check_all();

        // R6: hold bit forces threshold and ignores writes
        wr(1, 1, 4);
        wr(2, 0, 2'b01);
        settle();
        check("R6 held threshold forced", int'(thresh_o[3:0]), 15);
        check("R6 held core line low", int'(irq_o[0]), 0);
        wr(1, 0, 1);
        settle();
        check("R6 write ignored while held", int'(thresh_o[3:0]), 15);
        wr(2, 0, 0);
        settle();
        check("R6 stays 15 after release", int'(thresh_o[3:0]), 15);
        check_all();

        // R7: multicast dispatch, unaffected by threshold 15 on core0
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'h30; wr_data = 7'h03;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 multicast pulse", int'(ipi_o), 3);
        @(negedge clk);
        check("R7 pulse lasts one cycle", int'(ipi_o), 0);
        wr(3, 0, 2);
        check("R7 single target", int'(ipi_o), 2);

        // R11 and everything above: constrained random traffic
        wr(1, 0, 0);
        wr(1, 1, 1);
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                int d;
                d = int'($urandom % 16) | ((($urandom % 4) == 0) ? 16 : 0) | (int'($urandom % 4) << 5);
                wr(0, int'($urandom % 16), d);
            end else if (op < 5) begin
                pulse_src(16'($urandom) & 16'($urandom));
            end else if (op == 5) begin
                wr(1, int'($urandom % 2), (($urandom % 6) == 0) ? 15 : int'($urandom % 8));
            end else if (op < 8) begin
                do_ack(int'($urandom % 2));
            end else if (op == 8) begin
                do_eoi(int'($urandom % 2));
            end else begin
                if (($urandom % 6) == 0) wr(2, 0, int'($urandom % 4));
                else if (m_rst[0] || m_rst[1]) wr(2, 0, 0);
                else wr(3, 0, int'($urandom % 4));
            end
            settle();
            check_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule